// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block is a small instruction store between a pipelined CPU's fetch stage and a slower, streaming instruction memory. It does not cache ordinary lines. It keeps only short runs of instructions that begin at the destination of a taken branch, jump or call. A run is captured only when that destination misses and the CPU pipeline is starved. Straight-line code always comes from memory, which streams one word per cycle once it has started.

When the CPU redirects to a target that is resident, the block lookups in the cycle of the redirect. It starts playing the cached run in the next cycle and asks memory for the address just after the run in the same cycle. The memory's restart latency is therefore hidden behind the cached words. When the memory latency equals the run length, the fetch stream passes from cache to memory with no bubble. Only the entry point of each loop or routine has to be resident, so loops and call targets larger than the whole cache still gain.

Entries are fully associative and are replaced in round-robin order. A flush input empties the cache in one cycle. A code-write input invalidates any run that covers the written address.

Top module: `bt_icache`

## Requirements
- R1: After reset, `fetch_valid` and `mem_req` are low and no entry is valid, so the first redirect to any target misses.
- R2: A redirect that misses raises `mem_req` in the same cycle with `mem_addr` equal to the target. Fetch output is registered: a word that memory presents in one cycle appears on the fetch port in the next cycle. `fetch_valid` stays low from the cycle after the redirect until then.
- R3: A redirect that hits raises `mem_req` in the same cycle with `mem_addr` equal to target+RUN. It presents the target word in the next cycle and the RUN cached words on consecutive cycles. With a memory latency of RUN cycles, memory words follow the last cached word with no gap.
- R4: A run is allocated only when a redirect misses while `pipe_empty` is high. A miss with `pipe_empty` low leaves the cache unchanged, so the same target misses again.
- R5: Addresses reached by sequential fetch are never allocated. A redirect to an address that was only streamed past, including target+1 of a resident run, misses.
- R6: A fill captures the first RUN words that memory returns after the allocating redirect. The entry becomes valid only once all RUN words are held. A redirect before that leaves the entry invalid.
- R7: ENTRIES runs are held at once in any combination of targets, with no two entries holding the same tag. Victims are chosen in round-robin order, so ENTRIES+1 allocations evict the oldest run while the other runs stay resident.
- R8: `flush` clears every entry in one cycle. A redirect in the same cycle as `flush` misses and allocates nothing, even with `pipe_empty` high.
- R9: A `code_wr` pulse invalidates every entry whose run [tag, tag+RUN) contains `code_wr_addr`. It also abandons a fill in progress for such a run. Runs that do not contain the address stay resident.
- R10: A redirect during playback of a cached run stops the playback at once and starts a new lookup, so no further word of the old run is presented.
- R11: Every word on the fetch port has `fetch_pc` one greater than the previous word, unless a redirect came between them. Its `fetch_instr` equals the memory contents at `fetch_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| redirect | input | 1 | Taken branch, jump or call this cycle |
| redirect_pc | input | AW | Word address of the branch target |
| pipe_empty | input | 1 | CPU pipeline starved, waiting on fetch |
| code_wr | input | 1 | Instruction memory was written |
| code_wr_addr | input | AW | Word address that was written |
| mem_req | output | 1 | Start a memory stream at `mem_addr` |
| mem_addr | output | AW | First word address of the new stream |
| mem_valid | input | 1 | Memory presents a stream word |
| mem_data | input | DW | Stream word |
| fetch_valid | output | 1 | Fetch word valid |
| fetch_pc | output | AW | Address of the fetch word |
| fetch_instr | output | DW | Instruction word |

## Verification
The bench sweeps every entry through round-robin replacement and checks that the oldest run is evicted while the other eight stay resident. A design that miscounted the pointer would evict the wrong run or keep a stale one. The bench interrupts a fill after two words and a playback after one word. A design that marked a partial run valid would later hit and return words it never captured. A design that kept playing after a redirect would present old-run words where the new target was expected.

Fetch latency after every redirect is measured. This exposes allocation on sequential addresses, allocation while the pipeline is busy, and a flush that fails to suppress a same-cycle hit. Each of these turns an expected miss into an early hit. Code writes are placed inside, just past and mid-fill of runs, with the memory image changed. A design with a wrong range test, in either direction, would either serve outdated words or throw away a run that should have survived.

// File: rtl/bt_icache.sv
module bt_icache #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int RUN     = 4,
  parameter int ENTRIES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_pc,
  input  logic          pipe_empty,
  input  logic          code_wr,
  input  logic [AW-1:0] code_wr_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_data,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_pc,
  output logic [DW-1:0] fetch_instr
);
  // RUN and ENTRIES are powers of two, at least 2
  localparam int IW = $clog2(ENTRIES);
  localparam int CW = $clog2(RUN);

  logic [ENTRIES-1:0] valid, match, covered;
  logic [AW-1:0]      tag  [ENTRIES];
  logic [DW-1:0]      data [ENTRIES][RUN];
  logic [IW-1:0]      rr, hit_idx, play_idx, fill_idx;
  logic [CW-1:0]      play_cnt, fill_cnt;
  logic               play_on, fill_on, hit, alloc, take_mem;
  logic [AW-1:0]      stream_pc, out_pc;
  logic [DW-1:0]      out_w;
  logic               out_v;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign match[g]   = valid[g] && (tag[g] == redirect_pc);
    assign covered[g] = AW'(code_wr_addr - tag[g]) < AW'(RUN);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_idx = IW'(i);
  end

  assign hit      = redirect && !flush && (|match);
  assign alloc    = redirect && !flush && !(|match) && pipe_empty;
  assign take_mem = mem_valid && !redirect && !play_on;
  assign mem_req  = redirect;
  assign mem_addr = hit ? redirect_pc + AW'(RUN) : redirect_pc;

  assign fetch_valid = out_v;
  assign fetch_pc    = out_pc;
  assign fetch_instr = out_w;

  always_ff @(posedge clk) begin
    if (alloc) tag[rr] <= redirect_pc;
    if (fill_on && take_mem) data[fill_idx][fill_cnt] <= mem_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= '0;
      rr        <= '0;
      play_on   <= 1'b0;
      play_idx  <= '0;
      play_cnt  <= '0;
      fill_on   <= 1'b0;
      fill_idx  <= '0;
      fill_cnt  <= '0;
      stream_pc <= '0;
      out_v     <= 1'b0;
      out_pc    <= '0;
      out_w     <= '0;
    end else begin
      out_v <= 1'b0;
      if (redirect) begin
        play_on   <= hit;
        play_idx  <= hit_idx;
        play_cnt  <= CW'(1);
        stream_pc <= mem_addr;
        fill_on   <= alloc;
        fill_idx  <= rr;
        fill_cnt  <= '0;
        if (hit) begin
          out_v  <= 1'b1;
          out_pc <= redirect_pc;
          out_w  <= data[hit_idx][0];
        end
        if (alloc) begin
          valid[rr] <= 1'b0;
          rr        <= rr + 1'b1;
        end
      end else if (play_on) begin
        out_v    <= 1'b1;
        out_pc   <= out_pc + 1'b1;
        out_w    <= data[play_idx][play_cnt];
        play_cnt <= play_cnt + 1'b1;
        if (play_cnt == CW'(RUN - 1)) play_on <= 1'b0;
      end else if (mem_valid) begin
        out_v     <= 1'b1;
        out_pc    <= stream_pc;
        out_w     <= mem_data;
        stream_pc <= stream_pc + 1'b1;
        if (fill_on) begin
          fill_cnt <= fill_cnt + 1'b1;
          if (fill_cnt == CW'(RUN - 1)) begin
            fill_on         <= 1'b0;
            valid[fill_idx] <= 1'b1;
          end
        end
      end
      if (code_wr) begin
        for (int i = 0; i < ENTRIES; i++)
          if (covered[i]) valid[i] <= 1'b0;
        if (!redirect && fill_on && covered[fill_idx]) fill_on <= 1'b0;
      end
      if (flush) begin
        valid   <= '0;
        fill_on <= 1'b0;
      end
    end
  end

  a_r2_miss_goes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !hit) |=> !fetch_valid);

  a_r3_hit_serves_target: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && hit) |=> (fetch_valid && fetch_pc == $past(redirect_pc)));

  a_r4_busy_pipe_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !pipe_empty) |=> !fill_on);

  a_r5_fill_starts_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_on) |-> $past(redirect));

  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0));

  a_r11_pc_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && $past(fetch_valid) && !$past(redirect)) |-> fetch_pc == $past(fetch_pc) + 1'b1);
endmodule

// File: tb/bt_icache_test.sv
`timescale 1ns/1ps
module bt_icache_test;
  localparam int AW = 16, DW = 32, RUN = 4, ENT = 8, LAT = RUN;

  logic clk = 0, rst_n = 0;
  logic flush = 0, redirect = 0, pipe_empty = 0, code_wr = 0;
  logic [AW-1:0] redirect_pc = '0, code_wr_addr = '0;
  logic mem_req, mem_valid, fetch_valid;
  logic [AW-1:0] mem_addr, fetch_pc;
  logic [DW-1:0] mem_data, fetch_instr;

  int checks = 0, errors = 0;
  logic [AW-1:0] exp_pc = '0;
  logic patch_on = 0;
  logic [AW-1:0] patch_addr = '0;

  logic [AW-1:0] m_addr;
  int m_cnt;
  logic m_on;

  always #4 clk = ~clk;

  bt_icache #(.AW(AW), .DW(DW), .RUN(RUN), .ENTRIES(ENT)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .redirect(redirect),
    .redirect_pc(redirect_pc), .pipe_empty(pipe_empty), .code_wr(code_wr),
    .code_wr_addr(code_wr_addr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_data(mem_data), .fetch_valid(fetch_valid),
    .fetch_pc(fetch_pc), .fetch_instr(fetch_instr));

  function automatic logic [DW-1:0] memfn(input logic [AW-1:0] a);
    if (patch_on && a == patch_addr) return {16'hBEEF, a};
    return {~a, a};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on <= 1'b0; m_cnt <= 0; m_addr <= '0;
    end else if (mem_req) begin
      m_on <= 1'b1; m_cnt <= LAT - 1; m_addr <= mem_addr;
    end else if (m_on) begin
      if (m_cnt != 0) m_cnt <= m_cnt - 1;
      else m_addr <= m_addr + 1'b1;
    end
  end
  assign mem_valid = m_on && (m_cnt == 0);
  assign mem_data  = memfn(m_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // R11: every presented word is checked against the memory image and pc order
  always @(negedge clk) begin
    if (rst_n && fetch_valid) begin
      chk(fetch_pc == exp_pc, "R11 pc order", fetch_pc, exp_pc);
      chk(fetch_instr == memfn(fetch_pc), "R11 data", fetch_instr, memfn(fetch_pc));
      exp_pc = fetch_pc + 1'b1;
    end
  end

  task automatic jump(input logic [AW-1:0] t, input logic pe, input logic fl,
                      input logic exp_hit, input string req);
    int n;
    logic [AW-1:0] ea;
    @(negedge clk);
    redirect = 1; redirect_pc = t; pipe_empty = pe; flush = fl;
    #1;
    ea = exp_hit ? t + AW'(RUN) : t;
    chk(mem_req && mem_addr == ea, {req, " mem request"}, {15'd0, mem_req, mem_addr}, {16'd1, ea});
    @(posedge clk); #1;
    redirect = 0; flush = 0; pipe_empty = 0;
    exp_pc = t;
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!fetch_valid && n < 20);
    chk(n == (exp_hit ? 1 : LAT + 1), {req, " latency"}, n, exp_hit ? 1 : LAT + 1);
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(fetch_valid, req, fetch_valid, 1);
    end
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1;
    @(posedge clk); #1; flush = 0;
  endtask

  task automatic write_code(input logic [AW-1:0] a);
    @(negedge clk);
    patch_on = 1; patch_addr = a; code_wr = 1; code_wr_addr = a;
    @(posedge clk); #1; code_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!fetch_valid && !mem_req, "R1 reset outputs", {fetch_valid, mem_req}, 0);
    rst_n = 1;

    jump(16'h0040, 1'b0, 1'b0, 1'b0, "R1 empty after reset");
    run(6, "R2 stream");

    jump(16'h0100, 1'b0, 1'b0, 1'b0, "R4 busy miss");
    run(8, "R4 stream");
    jump(16'h0100, 1'b0, 1'b0, 1'b0, "R4 busy pipe no alloc");
    run(4, "R4 stream");

    jump(16'h0200, 1'b1, 1'b0, 1'b0, "R2 starved miss");
    run(RUN + 2, "R6 fill stream");
    jump(16'h0200, 1'b0, 1'b0, 1'b1, "R6 captured run hits");
    run(12, "R3 seamless handover");

    jump(16'h0201, 1'b0, 1'b0, 1'b0, "R5 target+1 misses");
    run(4, "R5 stream");
    jump(16'h0206, 1'b0, 1'b0, 1'b0, "R5 streamed address misses");
    run(4, "R5 stream");

    jump(16'h0200, 1'b0, 1'b0, 1'b1, "R10 hit");
    jump(16'h0300, 1'b0, 1'b0, 1'b0, "R10 abort playback to miss");
    run(4, "R10 stream");
    jump(16'h0200, 1'b0, 1'b0, 1'b1, "R10 hit again");
    run(1, "R10 playback");
    jump(16'h0200, 1'b0, 1'b0, 1'b1, "R10 relookup restarts run");
    run(8, "R10 stream");

    jump(16'h0400, 1'b1, 1'b0, 1'b0, "R6 alloc");
    run(1, "R6 partial");
    jump(16'h0500, 1'b0, 1'b0, 1'b0, "R6 interrupt fill");
    run(6, "R6 stream");
    jump(16'h0400, 1'b0, 1'b0, 1'b0, "R6 partial fill stays invalid");
    run(2, "R6 stream");

    pulse_flush();
    for (int k = 0; k <= ENT; k++) begin
      jump(AW'(16'h1000 + k * 16'h40), 1'b1, 1'b0, 1'b0, "R7 allocate");
      run(RUN + 1, "R7 fill");
    end
    for (int k = 1; k <= ENT; k++)
      jump(AW'(16'h1000 + k * 16'h40), 1'b0, 1'b0, 1'b1, "R7 resident");
    jump(16'h1000, 1'b0, 1'b0, 1'b0, "R7 oldest evicted");
    run(RUN + 1, "R7 stream");

    pulse_flush();
    jump(16'h1080, 1'b0, 1'b0, 1'b0, "R8 flushed entry misses");
    run(RUN + 1, "R8 stream");
    jump(16'h1100, 1'b1, 1'b0, 1'b0, "R8 alloc");
    run(RUN + 1, "R8 fill");
    jump(16'h1100, 1'b1, 1'b1, 1'b0, "R8 flush same cycle misses");
    run(RUN + 1, "R8 stream");
    jump(16'h1100, 1'b0, 1'b0, 1'b0, "R8 no alloc on flush cycle");
    run(RUN + 1, "R8 stream");

    jump(16'h2000, 1'b1, 1'b0, 1'b0, "R9 alloc");
    run(RUN + 1, "R9 fill");
    jump(16'h2000, 1'b0, 1'b0, 1'b1, "R9 resident");
    run(RUN + 2, "R9 stream");
    write_code(16'h2003);
    jump(16'h2000, 1'b0, 1'b0, 1'b0, "R9 covered write invalidates");
    run(RUN + 2, "R9 new data");

    jump(16'h2100, 1'b1, 1'b0, 1'b0, "R9 alloc outside");
    run(RUN + 1, "R9 fill");
    write_code(16'h2104);
    jump(16'h2100, 1'b0, 1'b0, 1'b1, "R9 write past run kept");
    run(RUN + 2, "R9 stream");
    write_code(16'h20FF);
    jump(16'h2100, 1'b0, 1'b0, 1'b1, "R9 write before run kept");
    run(2, "R9 stream");

    jump(16'h2200, 1'b1, 1'b0, 1'b0, "R9 alloc for mid-fill write");
    write_code(16'h2203);
    run(RUN + 1, "R9 stream");
    jump(16'h2200, 1'b0, 1'b0, 1'b0, "R9 write during fill aborts");
    run(RUN + 1, "R9 stream");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule